// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Controller with Atomic Set/Clear Writes

This block controls 32 general-purpose pins arranged as two banks of 16. Each bank holds eight per-pin control registers: output value, output enable, open-drain enable, pull-up enable, pull-down enable, input invert, output invert and input enable. Software never needs a read-modify-write to change one pin. Every register write is 32 bits wide. Its lower half names the pins whose bit is to be set, and its upper half names the pins whose bit is to be cleared. A pin named in neither half keeps its value.

From the register contents the block computes the pad controls for each pin: the driven level, the output enable, open-drain behaviour and the pull requests. It also conditions the level read back from each pad. The pad level is optionally inverted and gated by the input enable, and it then passes through a two-flop synchronizer before internal logic sees it. Readback is combinational and returns the addressed register in the low 16 bits.

Top module: `gpio_setclr_top`

## Requirements
- R1: After reset, all sixteen registers read zero, `pad_oe`, `pad_pu`, `pad_pd` and `gpio_in` are all zero, and so every pin starts as an undriven input with input disabled.
- R2: On a write, bit n of `wr_data[15:0]` sets bit n of the addressed register on the clock edge that samples `wr_en`.
- R3: On a write, bit n+16 of `wr_data` clears bit n of the addressed register. When the set bit and the clear bit for the same pin are both 1, the result is 0.
- R4: A write leaves unchanged every register bit whose set and clear bits are both 0. It also leaves every other register and the other bank unchanged. With `wr_en` low, no register changes.
- R5: Address bit 3 selects the bank: 0 selects pins 0–15 and 1 selects pins 16–31, with the pin at bit (pin mod 16). Address bits 2:0 select the register: 0 output value, 1 output enable, 2 open-drain, 3 pull-up, 4 pull-down, 5 input invert, 6 output invert, 7 input enable. `rd_data[15:0]` returns the register at `rd_addr` with no clock delay, and `rd_data[31:16]` is zero.
- R6: With open-drain off, `pad_out` equals output value XOR output invert, and `pad_oe` equals the output enable bit.
- R7: With open-drain on, `pad_out` is 0, and `pad_oe` is 1 only when output enable is 1 and the level (output value XOR output invert) is 0.
- R8: `pad_pu` equals the pull-up bit, and `pad_pd` equals the pull-down bit AND NOT the pull-up bit.
- R9: `gpio_in` equals (`pad_in` XOR input invert) AND input enable, delayed by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: bank in bit 3, register in bits 2:0 |
| wr_data | input | 32 | Set mask in bits 15:0, clear mask in bits 31:16 |
| rd_addr | input | 4 | Readback address, same encoding as `wr_addr` |
| rd_data | output | 32 | Addressed register in bits 15:0 |
| pad_in | input | 32 | Level sensed at each pad |
| pad_out | output | 32 | Level to drive on each pad |
| pad_oe | output | 32 | Pad driver enable |
| pad_pu | output | 32 | Pull-up request |
| pad_pd | output | 32 | Pull-down request |
| gpio_in | output | 32 | Conditioned, synchronized input value |

## Verification
The register assertions assume that a write's address and data are valid whenever `wr_en` is high. They also assume that the set and clear masks may overlap freely, and the stimulus deliberately includes overlapping masks. The synchronizer assertion assumes that `pad_in` and the configuration can change on any cycle, with reset holding the configuration at zero so that the two-cycle history is defined. The bench changes all inputs only on falling edges and applies reset before each directed group, so every sampled value has a single defined history.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BANK_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [IDX_W-1:0] REG_OUT  = 3'd0;
    localparam logic [IDX_W-1:0] REG_OE   = 3'd1;
    localparam logic [IDX_W-1:0] REG_OD   = 3'd2;
    localparam logic [IDX_W-1:0] REG_PU   = 3'd3;
    localparam logic [IDX_W-1:0] REG_PD   = 3'd4;
    localparam logic [IDX_W-1:0] REG_IINV = 3'd5;
    localparam logic [IDX_W-1:0] REG_OINV = 3'd6;
    localparam logic [IDX_W-1:0] REG_IEN  = 3'd7;

    typedef struct packed {
        logic [BANK_W-1:0] out_val;
        logic [BANK_W-1:0] out_en;
        logic [BANK_W-1:0] od_en;
        logic [BANK_W-1:0] pu_en;
        logic [BANK_W-1:0] pd_en;
        logic [BANK_W-1:0] in_inv;
        logic [BANK_W-1:0] out_inv;
        logic [BANK_W-1:0] in_en;
    } bank_cfg_t;

    typedef struct packed {
        logic [NUM_REGS-1:0][BANK_W-1:0] r;
    } bank_state_t;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [2*BANK_W-1:0] wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [BANK_W-1:0]   rd_val,
    output bank_cfg_t           cfg
);
    bank_state_t st_d, st_q;
    logic [BANK_W-1:0] set_m, clr_m;

    assign set_m = wr_data[BANK_W-1:0];
    assign clr_m = wr_data[2*BANK_W-1:BANK_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.r[wr_idx] = (st_q.r[wr_idx] | set_m) & ~clr_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_val       = st_q.r[rd_idx];
    assign cfg.out_val  = st_q.r[REG_OUT];
    assign cfg.out_en   = st_q.r[REG_OE];
    assign cfg.od_en    = st_q.r[REG_OD];
    assign cfg.pu_en    = st_q.r[REG_PU];
    assign cfg.pd_en    = st_q.r[REG_PD];
    assign cfg.in_inv   = st_q.r[REG_IINV];
    assign cfg.out_inv  = st_q.r[REG_OINV];
    assign cfg.in_en    = st_q.r[REG_IEN];

    // R2
    set_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((st_q.r[$past(wr_idx)] & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));
    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((st_q.r[$past(wr_idx)] & $past(clr_m)) == '0));
    // R4
    untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((st_q.r[$past(wr_idx)] ^ $past(st_q.r[wr_idx])) & ~$past(set_m | clr_m)) == '0));
    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));
endmodule

// File: rtl/gpio_pad_logic.sv
module gpio_pad_logic
    import gpio_pkg::*;
(
    input  bank_cfg_t         cfg,
    input  logic [BANK_W-1:0] pad_in,
    output logic [BANK_W-1:0] pad_out,
    output logic [BANK_W-1:0] pad_oe,
    output logic [BANK_W-1:0] pad_pu,
    output logic [BANK_W-1:0] pad_pd,
    output logic [BANK_W-1:0] in_raw
);
    logic [BANK_W-1:0] level;

    always_comb begin
        level   = cfg.out_val ^ cfg.out_inv;
        pad_out = level & ~cfg.od_en;
        pad_oe  = cfg.out_en & (~cfg.od_en | ~level);
        pad_pu  = cfg.pu_en;
        pad_pd  = cfg.pd_en & ~cfg.pu_en;
        in_raw  = (pad_in ^ cfg.in_inv) & cfg.in_en;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d_in;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q_out = sy_q.s2;

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_out == $past(d_in, 2));
endmodule

// File: rtl/gpio_setclr_top.sv
module gpio_setclr_top
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic [31:0] pad_in,
    output logic [31:0] pad_out,
    output logic [31:0] pad_oe,
    output logic [31:0] pad_pu,
    output logic [31:0] pad_pd,
    output logic [31:0] gpio_in
);
    localparam int PINS = NUM_BANKS * BANK_W;

    logic [NUM_BANKS-1:0][BANK_W-1:0] rd_val;
    logic [PINS-1:0]                  in_raw;
    logic [PINS-1:0]                  od_all;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cfg_t cfg;
        logic      hit;
        assign hit = wr_en && (wr_addr[IDX_W] == b[0]);

        gpio_bank_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit),
            .wr_idx  (wr_addr[IDX_W-1:0]),
            .wr_data (wr_data),
            .rd_idx  (rd_addr[IDX_W-1:0]),
            .rd_val  (rd_val[b]),
            .cfg     (cfg)
        );

        gpio_pad_logic u_pad (
            .cfg     (cfg),
            .pad_in  (pad_in[b*BANK_W +: BANK_W]),
            .pad_out (pad_out[b*BANK_W +: BANK_W]),
            .pad_oe  (pad_oe[b*BANK_W +: BANK_W]),
            .pad_pu  (pad_pu[b*BANK_W +: BANK_W]),
            .pad_pd  (pad_pd[b*BANK_W +: BANK_W]),
            .in_raw  (in_raw[b*BANK_W +: BANK_W])
        );

        assign od_all[b*BANK_W +: BANK_W] = cfg.od_en;
    end

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (in_raw),
        .q_out (gpio_in)
    );

    assign rd_data = {{(32-BANK_W){1'b0}}, rd_val[rd_addr[IDX_W]]};

    // R8
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);
    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od_all & pad_oe & pad_out) == '0);
endmodule

// File: tb/gpio_setclr_top_bench.sv
module gpio_setclr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, gpio_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_setclr_top u_gpio_setclr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .gpio_in(gpio_in)
    );

    // {write addr, write data, read addr, expected low half}
    localparam logic [55:0] VEC [10] = '{
        {4'h0, 32'h0000_00FF, 4'h0, 16'h00FF},   // R2 set
        {4'h0, 32'h0000_0F00, 4'h0, 16'h0FFF},   // R2/R4 accumulate
        {4'h0, 32'h0003_0000, 4'h0, 16'h0FFC},   // R3 clear
        {4'h0, 32'h0010_0010, 4'h0, 16'h0FEC},   // R3 clear wins
        {4'h0, 32'h0000_0000, 4'h0, 16'h0FEC},   // R4 empty write
        {4'h8, 32'h0000_A5A5, 4'h8, 16'hA5A5},   // R5 high bank
        {4'h1, 32'h0000_FFFF, 4'h0, 16'h0FEC},   // R4 other register
        {4'h9, 32'hFFFF_0001, 4'h9, 16'h0000},   // R3 overlap
        {4'h8, 32'hFFFF_0000, 4'h0, 16'h0FEC},   // R4/R5 other bank
        {4'hF, 32'h0000_8001, 4'hF, 16'h8001}    // R5 input enable slot
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pad_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd_addr = a[3:0];
            #1 chk("R1 reg zero", rd_data, 32'h0);
        end
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_pu", pad_pu, 32'h0);
        chk("R1 pad_pd", pad_pd, 32'h0);
        chk("R1 gpio_in", gpio_in, 32'h0);

        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][55:52], VEC[i][51:20]);
            rd_addr = VEC[i][19:16];
            #1 chk("R2/R3/R4/R5 table", rd_data, {16'h0, VEC[i][15:0]});
        end

        // R6 push-pull drive
        do_reset();
        wr(4'h0, 32'h0000_0001);
        wr(4'h1, 32'h0000_0001);
        chk("R6 level", {31'b0, pad_out[0]}, 32'h1);
        chk("R6 oe", {31'b0, pad_oe[0]}, 32'h1);
        wr(4'h6, 32'h0000_0001);
        chk("R6 inverted level", {31'b0, pad_out[0]}, 32'h0);
        chk("R6 oe kept", {31'b0, pad_oe[0]}, 32'h1);

        // R7 open-drain on pin 17
        wr(4'h9, 32'h0000_0002);
        wr(4'hA, 32'h0000_0002);
        chk("R7 drive low oe", {31'b0, pad_oe[17]}, 32'h1);
        chk("R7 drive low out", {31'b0, pad_out[17]}, 32'h0);
        wr(4'h8, 32'h0000_0002);
        chk("R7 release oe", {31'b0, pad_oe[17]}, 32'h0);
        chk("R7 release out", {31'b0, pad_out[17]}, 32'h0);

        // R8 pulls on pin 3
        wr(4'h4, 32'h0000_0008);
        chk("R8 pd alone", {31'b0, pad_pd[3]}, 32'h1);
        wr(4'h3, 32'h0000_0008);
        chk("R8 pu", {31'b0, pad_pu[3]}, 32'h1);
        chk("R8 pd suppressed", {31'b0, pad_pd[3]}, 32'h0);

        // R9 input path on pin 20
        pad_in[20] = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R9 gated off", {31'b0, gpio_in[20]}, 32'h0);
        wr(4'hF, 32'h0000_0010);
        @(negedge clk);
        chk("R9 one edge", {31'b0, gpio_in[20]}, 32'h0);
        @(negedge clk);
        chk("R9 two edges", {31'b0, gpio_in[20]}, 32'h1);
        wr(4'hD, 32'h0000_0010);
        @(negedge clk);
        chk("R9 invert one edge", {31'b0, gpio_in[20]}, 32'h1);
        @(negedge clk);
        chk("R9 invert two edges", {31'b0, gpio_in[20]}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule